// File: doc/BRIEF.md
# Discrete-Input Sensor Register Slave over SPI

This block is the serial register front of a 32-channel discrete-input sensing device. A host talks to it over SPI in mode 0. Each transaction opens with one command byte. The top bit of that byte chooses between read and write, and the lower seven bits name a register. On a write, the data bytes that follow are stored. On a read, the addressed value is shifted back most significant byte first, starting at the first clock of the byte that follows the command.

The registers cover four things. A control register holds a test bit and a soft-reset bit. A sensing-mode register holds one bit for each bank of eight channels. Two 16-bit threshold words serve the two sensing modes. The live channel states can be read either as byte-wide slices or as a single 32-bit big-endian burst. The stored values drive the sensing logic directly through output ports. The SPI pins and the channel inputs are brought into the system clock domain through two-flop synchronizers, so SCLK must run well below the system clock.

Top module: `discin_spi_regs`

## Requirements
- R1: The first byte of each transaction is a command. Bit 7 = 1 means read and bit 7 = 0 means write. Bits 6:0 are the register address.
- R2: SPI mode 0. MOSI is sampled on rising SCLK. MISO changes only after falling SCLK. The first data bit of a read is valid at the first rising edge after the command byte, and every value is sent most significant bit and byte first.
- R3: The control register at 0x02 holds bit 0 (test) and bit 1 (soft reset) and reads back both bits. `test_mode` follows bit 0 while bit 1 is clear.
- R4: While control bit 1 is set, the sensing-mode register is held at 0 and both thresholds are held at 0x0206. Writes to those registers are ignored and `test_mode` is 0. Writing 0 to control releases the soft reset.
- R5: The sensing-mode register at 0x04 holds bit n for the bank of channels 8n to 8n+7 (1 = supply-open, 0 = ground-open). It reads back in bits 3:0 and drives `bank_mode`.
- R6: The ground-open threshold is at 0x3A and the supply-open threshold is at 0x3C. Each is 16 bits wide, written as two data bytes with the high byte first, and updated only when the second byte completes. Each reads back as two bytes.
- R7: Addresses 0x10, 0x12, 0x14 and 0x16 return channels 7:0, 15:8, 23:16 and 31:24. The lowest channel of each slice is in bit 0.
- R8: Address 0x78 returns all 32 channel states as four bytes, with channel 31 in the MSB of the first byte.
- R9: Deasserting chip select ends a transaction. A partial byte is discarded. A threshold write cut off after one data byte leaves the threshold unchanged. Data bytes beyond a register's width are ignored.
- R10: A read of an unmapped address returns 0x00. A write to an unmapped or read-only address changes no register.
- R11: After hardware reset, control and mode are 0, both thresholds are 0x0206, and MISO is 0 while chip select is high.
- R12: Read bytes clocked out beyond the addressed register's width are 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| chan_state | input | 32 | Comparator state of each channel |
| test_mode | output | 1 | Test bit to the sensing logic |
| bank_mode | output | 4 | Sensing mode per bank of eight channels |
| gnd_thr | output | 16 | Ground-open threshold word |
| sup_thr | output | 16 | Supply-open threshold word |

## Verification
The embedded assertions check on every cycle that the control, mode and threshold registers change only after a decoded write to their own address or during soft reset. They also check that the mode register reads zero once soft reset has been seen, and that MISO moves only after a falling SCLK or a deselect. The bench scenarios are needed for the rest:
- byte ordering of multi-byte reads;
- the mapping of channel slices to addresses;
- the discarding of partial and truncated writes;
- zero fill past a register's width;
- the sequence of entering and releasing soft reset.

// File: rtl/discin_pkg.sv
package discin_pkg;
  localparam int THR_W = 16;
  localparam logic [6:0] ADR_CTRL  = 7'h02;
  localparam logic [6:0] ADR_MODE  = 7'h04;
  localparam logic [6:0] ADR_GTHR  = 7'h3A;
  localparam logic [6:0] ADR_STHR  = 7'h3C;
  localparam logic [6:0] ADR_WORD  = 7'h78;
  localparam int         SLICE_BASE = 16;

  // address of the k-th byte-wide channel slice
  function automatic logic [6:0] slice_addr(input int k);
    return 7'(SLICE_BASE + 2 * k);
  endfunction

  // place an nbytes-wide value at the top of a 32-bit shift word
  function automatic logic [31:0] left_align(input logic [31:0] v, input int nbytes);
    return v << (8 * (4 - nbytes));
  endfunction
endpackage

// File: rtl/discin_spi_front.sv
module discin_spi_front (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk,
  input  logic        cs_n,
  input  logic        mosi,
  input  logic [31:0] rd_word,
  output logic        miso,
  output logic        byte_valid,
  output logic [7:0]  byte_data,
  output logic [2:0]  byte_idx
);
  logic [1:0] sclk_sy, cs_sy, mosi_sy;
  logic       sclk_d;
  logic       sclk_s, cs_s, mosi_s;
  logic       sclk_rise, sclk_fall;
  logic [2:0] bit_cnt;
  logic [6:0] sh_in;
  logic [31:0] out_sh;
  logic       miso_q;

  assign sclk_s = sclk_sy[1];
  assign cs_s   = cs_sy[1];
  assign mosi_s = mosi_sy[1];
  assign sclk_rise = ~cs_s & sclk_s & ~sclk_d;
  assign sclk_fall = ~cs_s & ~sclk_s & sclk_d;

  assign byte_valid = sclk_rise && (bit_cnt == 3'd7);
  assign byte_data  = {sh_in, mosi_s};
  assign miso       = miso_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy <= 2'b00;
      cs_sy   <= 2'b11;
      mosi_sy <= 2'b00;
      sclk_d  <= 1'b0;
    end else begin
      sclk_sy <= {sclk_sy[0], sclk};
      cs_sy   <= {cs_sy[0], cs_n};
      mosi_sy <= {mosi_sy[0], mosi};
      sclk_d  <= sclk_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      byte_idx <= '0;
      sh_in    <= '0;
      out_sh   <= '0;
      miso_q   <= 1'b0;
    end else if (cs_s) begin
      bit_cnt  <= '0;
      byte_idx <= '0;
      out_sh   <= '0;
      miso_q   <= 1'b0;
    end else begin
      if (sclk_rise) begin
        sh_in   <= {sh_in[5:0], mosi_s};
        bit_cnt <= bit_cnt + 3'd1;
        if (byte_valid) begin
          if (byte_idx != 3'd7) byte_idx <= byte_idx + 3'd1;
          if (byte_idx == 3'd0 && byte_data[7]) out_sh <= rd_word;
        end
      end
      if (sclk_fall) begin
        miso_q <= out_sh[31];
        out_sh <= {out_sh[30:0], 1'b0};
      end
    end
  end

  // R2
  miso_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso_q) |-> ($past(sclk_fall) || $past(cs_s)));

  // R9
  idx_clear_on_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_s) |-> (byte_idx == 3'd0 && bit_cnt == 3'd0));
endmodule

// File: rtl/discin_regfile.sv
module discin_regfile
  import discin_pkg::*;
#(
  parameter int              NUM_CH      = 32,
  parameter logic [THR_W-1:0] THR_DEFAULT = 16'h0206,
  localparam int             BANKS       = NUM_CH / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic [2:0]        byte_idx,
  input  logic [NUM_CH-1:0] chan_in,
  output logic [31:0]       rd_word,
  output logic              test_mode,
  output logic [BANKS-1:0]  bank_mode,
  output logic [THR_W-1:0]  gnd_thr,
  output logic [THR_W-1:0]  sup_thr
);
  logic [7:0]        cmd_q;
  logic [1:0]        ctrl_q;
  logic [BANKS-1:0]  mode_q;
  logic [THR_W-1:0]  gthr_q, sthr_q;
  logic [7:0]        thr_hi_q;
  logic [NUM_CH-1:0] ch_m, ch_s;
  logic              srst, is_wr;
  logic [6:0]        addr_q, rd_addr;
  logic              ctrl_commit, mode_commit, hi_load, gthr_commit, sthr_commit;

  assign srst   = ctrl_q[1];
  assign is_wr  = ~cmd_q[7];
  assign addr_q = cmd_q[6:0];
  assign rd_addr = byte_data[6:0];

  assign ctrl_commit = byte_valid && byte_idx == 3'd1 && is_wr && addr_q == ADR_CTRL;
  assign mode_commit = byte_valid && byte_idx == 3'd1 && is_wr && addr_q == ADR_MODE;
  assign hi_load     = byte_valid && byte_idx == 3'd1 && is_wr &&
                       (addr_q == ADR_GTHR || addr_q == ADR_STHR);
  assign gthr_commit = byte_valid && byte_idx == 3'd2 && is_wr && addr_q == ADR_GTHR;
  assign sthr_commit = byte_valid && byte_idx == 3'd2 && is_wr && addr_q == ADR_STHR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_m <= '0;
      ch_s <= '0;
    end else begin
      ch_m <= chan_in;
      ch_s <= ch_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (byte_valid && byte_idx == 3'd0) cmd_q <= byte_data;
      if (ctrl_commit) ctrl_q <= byte_data[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      gthr_q   <= THR_DEFAULT;
      sthr_q   <= THR_DEFAULT;
      thr_hi_q <= '0;
    end else if (srst) begin
      mode_q   <= '0;
      gthr_q   <= THR_DEFAULT;
      sthr_q   <= THR_DEFAULT;
      thr_hi_q <= '0;
    end else begin
      if (mode_commit) mode_q <= byte_data[BANKS-1:0];
      if (hi_load)     thr_hi_q <= byte_data;
      if (gthr_commit) gthr_q <= {thr_hi_q, byte_data};
      if (sthr_commit) sthr_q <= {thr_hi_q, byte_data};
    end
  end

  always_comb begin
    rd_word = '0;
    case (rd_addr)
      ADR_CTRL: rd_word = left_align(32'(ctrl_q), 1);
      ADR_MODE: rd_word = left_align(32'(mode_q), 1);
      ADR_GTHR: rd_word = left_align(32'(gthr_q), 2);
      ADR_STHR: rd_word = left_align(32'(sthr_q), 2);
      ADR_WORD: rd_word = 32'(ch_s);
      default:  rd_word = '0;
    endcase
    for (int k = 0; k < BANKS; k++) begin
      if (rd_addr == slice_addr(k)) rd_word = left_align(32'(ch_s[8*k +: 8]), 1);
    end
  end

  assign test_mode = ctrl_q[0] & ~srst;
  assign bank_mode = mode_q;
  assign gnd_thr   = gthr_q;
  assign sup_thr   = sthr_q;

  // R3
  ctrl_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> $past(ctrl_commit));

  // R5
  mode_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> ($past(mode_commit) || $past(srst)));

  // R6
  gthr_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gthr_q) |-> ($past(gthr_commit) || $past(srst)));

  // R6
  sthr_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sthr_q) |-> ($past(sthr_commit) || $past(srst)));

  // R4
  srst_clears_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (mode_q == '0 && gthr_q == THR_DEFAULT && sthr_q == THR_DEFAULT));
endmodule

// File: rtl/discin_spi_regs.sv
module discin_spi_regs
  import discin_pkg::*;
#(
  parameter int               NUM_CH      = 32,
  parameter logic [THR_W-1:0] THR_DEFAULT = 16'h0206,
  localparam int              BANKS       = NUM_CH / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic [NUM_CH-1:0] chan_state,
  output logic              test_mode,
  output logic [BANKS-1:0]  bank_mode,
  output logic [THR_W-1:0]  gnd_thr,
  output logic [THR_W-1:0]  sup_thr
);
  logic        byte_valid;
  logic [7:0]  byte_data;
  logic [2:0]  byte_idx;
  logic [31:0] rd_word;

  discin_spi_front u_front (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk       (spi_sclk),
    .cs_n       (spi_cs_n),
    .mosi       (spi_mosi),
    .rd_word    (rd_word),
    .miso       (spi_miso),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .byte_idx   (byte_idx)
  );

  discin_regfile #(
    .NUM_CH      (NUM_CH),
    .THR_DEFAULT (THR_DEFAULT)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .byte_idx   (byte_idx),
    .chan_in    (chan_state),
    .rd_word    (rd_word),
    .test_mode  (test_mode),
    .bank_mode  (bank_mode),
    .gnd_thr    (gnd_thr),
    .sup_thr    (sup_thr)
  );
endmodule

// File: tb/discin_spi_regs_tb.sv
module discin_spi_regs_tb;
  localparam int HP = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic        miso;
  logic [31:0] chan = '0;
  logic        test_mode;
  logic [3:0]  bank_mode;
  logic [15:0] gnd_thr, sup_thr;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got_q[$];
  event       rx_ev;

  always #5 clk = ~clk;

  discin_spi_regs u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .chan_state(chan), .test_mode(test_mode), .bank_mode(bank_mode),
    .gnd_thr(gnd_thr), .sup_thr(sup_thr)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] expv);
    checks++;
    if (got !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, expv);
    end
  endtask

  // monitor: pop received bytes and compare with scoreboard
  initial forever begin
    @(rx_ev);
    while (got_q.size() > 0) begin
      logic [7:0] g;
      g = got_q.pop_front();
      if (exp_q.size() == 0) check("R2 unexpected byte", {24'h0, g}, 32'hx);
      else check(tag_q.pop_front(), {24'h0, g}, {24'h0, exp_q.pop_front()});
    end
  end

  task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tx[i];
      repeat (HP) @(negedge clk);
      rx[i] = miso;
      sclk = 1'b1;
      repeat (HP) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic sel;
    cs_n = 1'b0;
    repeat (HP) @(negedge clk);
  endtask

  task automatic desel;
    repeat (HP) @(negedge clk);
    cs_n = 1'b1;
    repeat (HP) @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d[$]);
    logic [7:0] r;
    sel();
    bits({1'b0, a}, 8, r);
    foreach (d[i]) bits(d[i], 8, r);
    desel();
  endtask

  // read n bytes; expected value left-aligned in ev
  task automatic rd(input logic [6:0] a, input int n, input logic [63:0] ev, input string req);
    logic [7:0] r;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(ev[63 - 8*i -: 8]);
      tag_q.push_back(req);
    end
    sel();
    bits({1'b1, a}, 8, r);
    for (int i = 0; i < n; i++) begin
      bits(8'h00, 8, r);
      got_q.push_back(r);
      -> rx_ev;
    end
    desel();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    check("R11 mode", {28'h0, bank_mode}, 32'h0);
    check("R11 gthr", {16'h0, gnd_thr}, 32'h0206);
    check("R11 sthr", {16'h0, sup_thr}, 32'h0206);
    check("R11 miso idle", {31'h0, miso}, 32'h0);
    check("R3 test reset", {31'h0, test_mode}, 32'h0);
    rd(7'h02, 1, 64'h00 << 56, "R11 ctrl read");

    // R1 R5 mode
    wr(7'h04, '{8'h05});
    check("R5 bank_mode", {28'h0, bank_mode}, 32'h5);
    rd(7'h04, 1, 64'h05 << 56, "R5 R1 mode read");

    // R6 thresholds, R2 byte order
    wr(7'h3A, '{8'h12, 8'h34});
    wr(7'h3C, '{8'hAB, 8'hCD});
    check("R6 gthr port", {16'h0, gnd_thr}, 32'h1234);
    check("R6 sthr port", {16'h0, sup_thr}, 32'hABCD);
    rd(7'h3A, 2, 64'h1234 << 48, "R6 R2 gthr read");
    rd(7'h3C, 2, 64'hABCD << 48, "R6 R2 sthr read");

    // R9 truncated threshold write
    wr(7'h3A, '{8'h77});
    check("R9 truncated thr", {16'h0, gnd_thr}, 32'h1234);
    // R9 partial byte
    sel(); bits(8'h04, 8, r); bits(8'h0F, 5, r); desel();
    check("R9 partial byte", {28'h0, bank_mode}, 32'h5);
    // R9 extra data bytes
    wr(7'h04, '{8'h06, 8'h09});
    check("R9 extra bytes", {28'h0, bank_mode}, 32'h6);

    // R7 R8 channel views
    chan = 32'hA1B2C3D4;
    repeat (6) @(negedge clk);
    rd(7'h10, 1, 64'hD4 << 56, "R7 slice0");
    rd(7'h12, 1, 64'hC3 << 56, "R7 slice1");
    rd(7'h14, 1, 64'hB2 << 56, "R7 slice2");
    rd(7'h16, 1, 64'hA1 << 56, "R7 slice3");
    rd(7'h78, 4, 64'hA1B2C3D4 << 32, "R8 word");
    // R12 zero fill
    rd(7'h78, 6, 64'hA1B2C3D4_0000 << 16, "R12 word fill");
    rd(7'h04, 2, 64'h0600 << 48, "R12 mode fill");

    // R10 unmapped and read-only
    rd(7'h20, 1, 64'h0, "R10 unmapped read");
    wr(7'h10, '{8'hFF});
    rd(7'h10, 1, 64'hD4 << 56, "R10 read-only write");
    wr(7'h30, '{8'hFF, 8'hFF});
    check("R10 unmapped write mode", {28'h0, bank_mode}, 32'h6);
    check("R10 unmapped write thr", {16'h0, gnd_thr}, 32'h1234);

    // R3 test bit
    wr(7'h02, '{8'h01});
    check("R3 test_mode", {31'h0, test_mode}, 32'h1);
    rd(7'h02, 1, 64'h01 << 56, "R3 ctrl read");

    // R4 soft reset
    wr(7'h02, '{8'h03});
    check("R4 test masked", {31'h0, test_mode}, 32'h0);
    check("R4 mode cleared", {28'h0, bank_mode}, 32'h0);
    check("R4 gthr default", {16'h0, gnd_thr}, 32'h0206);
    check("R4 sthr default", {16'h0, sup_thr}, 32'h0206);
    wr(7'h04, '{8'h0F});
    check("R4 mode write held", {28'h0, bank_mode}, 32'h0);
    wr(7'h3C, '{8'h11, 8'h22});
    check("R4 thr write held", {16'h0, sup_thr}, 32'h0206);
    rd(7'h02, 1, 64'h03 << 56, "R4 ctrl read");
    wr(7'h02, '{8'h00});
    wr(7'h04, '{8'h03});
    check("R4 release", {28'h0, bank_mode}, 32'h3);

    // R11 hardware reset
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 hw reset mode", {28'h0, bank_mode}, 32'h0);
    check("R11 hw reset thr", {16'h0, sup_thr}, 32'h0206);

    repeat (4) @(negedge clk);
    check("R2 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule